// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds a word of configurable width, by default eight bits. It fills the word from a parallel input bus. It then sends the word out one bit at a time from its last stage. It works inside one system clock domain.

The external shift clock and the clock-inhibit line arrive as ordinary sampled signals. The block registers both of them. It ORs the two registered values and looks for a low-to-high change of that combined value. Each such change moves the word one stage toward the output end, and the serial input fills stage 0.

An active-low load input takes priority over shifting. While load is low, the register follows the parallel bus. The outputs also follow the bus directly, with no clock edge needed. The last stage is always driven out in true form and in inverted form. Several instances can be chained: connect one instance's true output to the next instance's serial input.

Top module: `piso_shifter`

## Requirements
- R1: While `load_n` is 0, every stage takes `par_in` on each system clock, whatever `shift_clk`, `clk_inhibit` and `ser_in` do. A rise of the combined clock that happens while `load_n` is 0 causes no shift after `load_n` returns to 1.
- R2: While `load_n` is 0, `ser_out` equals `par_in[WIDTH-1]` in the same cycle. A change on that bit reaches the outputs with no system clock edge.
- R3: With `load_n` at 1, a 0-to-1 change of the combined clock (`shift_clk` OR `clk_inhibit`) shifts the register one place toward the last stage, and `ser_in` enters stage 0. A pin that rises just after system edge k, where k counts the system clock edges, shifts the register at edge k+2.
- R4: While either pin is held at 1, a rise on the other pin causes no shift.
- R5: A rise on `clk_inhibit` while `shift_clk` is 0 counts as a clock edge and causes one shift.
- R6: With `load_n` at 1 and no rise of the combined clock, all stages hold their values for any number of cycles.
- R7: `ser_out_n` is always the inverse of `ser_out`.
- R8: Reset (`rst_n` at 0) clears every stage and the edge history. After reset, with `load_n` at 1, `ser_out` is 0 and `ser_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_n | input | 1 | Active-low parallel load; overrides shifting |
| par_in | input | WIDTH | Parallel word; bit i feeds stage i |
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | External shift clock, sampled on `clk` |
| clk_inhibit | input | 1 | Second clock pin; the two pins are interchangeable and combined by OR |
| ser_out | output | 1 | Last stage, true form |
| ser_out_n | output | 1 | Last stage, inverted form |

## Verification
The assertions watch the stage register on every cycle:
- a capture of the bus while load is low;
- an exact one-place shift, with `ser_in` entering stage 0, on each detected rise;
- no change when the combined clock is low or stays high.

Some behaviour only the bench scenarios can show, because it depends on a sequence of pin changes or on what is seen at the outputs:
- the two-cycle latency from a pin change to a shift;
- the transparent path from the bus to the outputs while loading;
- a rise of the inhibit pin counting as a clock;
- an edge during loading being dropped after release;
- the full word appearing in order at the serial output.

// File: rtl/piso_shifter.sv
module piso_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             clk_inhibit,
  output logic             ser_out,
  output logic             ser_out_n
);

  localparam int LAST = WIDTH - 1;

  logic             clk_q, inh_q, comb_prev;
  logic             comb_now, step;
  logic [WIDTH-1:0] stages, view;

  assign comb_now = clk_q | inh_q;
  assign step     = load_n & comb_now & ~comb_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q     <= 1'b0;
      inh_q     <= 1'b0;
      comb_prev <= 1'b0;
      stages    <= '0;
    end else begin
      clk_q     <= shift_clk;
      inh_q     <= clk_inhibit;
      comb_prev <= comb_now;
      if (!load_n)
        stages <= par_in;
      else if (step)
        stages <= {stages[LAST-1:0], ser_in};
    end
  end

  assign view      = load_n ? stages : par_in;
  assign ser_out   = view[LAST];
  assign ser_out_n = ~view[LAST];

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> stages == $past(par_in));

  // R3
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && comb_now && !comb_prev) |=>
      (stages[0] == $past(ser_in)) && (stages[LAST:1] == $past(stages[LAST-1:0])));

  // R4
  held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && comb_now && comb_prev) |=> $stable(stages));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !comb_now) |=> $stable(stages));

endmodule

// File: tb/piso_shifter_test.sv
module piso_shifter_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b1;
  logic [W-1:0] par_in = '0;
  logic         ser_in = 1'b0;
  logic         shift_clk = 1'b0;
  logic         clk_inhibit = 1'b0;
  logic         ser_out, ser_out_n;

  always #5 clk = ~clk;

  piso_shifter #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .par_in(par_in),
    .ser_in(ser_in), .shift_clk(shift_clk), .clk_inhibit(clk_inhibit),
    .ser_out(ser_out), .ser_out_n(ser_out_n)
  );

  typedef struct { logic q; string tag; } item_t;
  item_t        sb[$];
  int           checks = 0;
  int           fails = 0;
  logic [W-1:0] model = '0;
  bit           done = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input logic e, input string tag);
    item_t it;
    #2;
    it.q = e;
    it.tag = tag;
    sb.push_back(it);
    #2;
  endtask

  task automatic pulse_clock(input logic sin, input string tag);
    ser_in = sin;
    shift_clk = 1'b1;
    tick(2);
    model = {model[W-2:0], sin};
    push_exp(model[W-1], tag);
    shift_clk = 1'b0;
    tick(2);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < W; i++) pulse_clock(i[0], tag);
  endtask

  // Monitor: the scoreboard also checks R7 on every item.
  initial begin
    item_t it;
    forever begin
      wait (sb.size() > 0);
      it = sb.pop_front();
      #1;
      checks++;
      if (ser_out !== it.q || ser_out_n !== ~it.q) begin
        fails++;
        $display("FAIL %s (R7 pair): ser_out=%b ser_out_n=%b expected %b/%b",
                 it.tag, ser_out, ser_out_n, it.q, ~it.q);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    push_exp(1'b0, "R8");
    push_exp(1'b0, "R7");

    // R2: outputs follow the bus while loading
    load_n = 1'b0;
    par_in = 8'hA5;
    push_exp(1'b1, "R2");
    tick(1);
    par_in = 8'h25;
    push_exp(1'b0, "R2");
    tick(1);
    par_in = 8'hA5;
    tick(1);
    load_n = 1'b1;
    model = 8'hA5;
    push_exp(1'b1, "R1");
    tick(1);

    // R3: word leaves in order, serial bits refill
    drain("R3");

    // R6: long idle hold
    tick(20);
    push_exp(model[W-1], "R6");

    // R5: inhibit rising while clock low shifts
    model = 8'h80;
    load_n = 1'b0; par_in = 8'h80; tick(1); load_n = 1'b1; tick(1);
    ser_in = 1'b1;
    clk_inhibit = 1'b1;
    tick(1);
    push_exp(1'b1, "R5");
    tick(1);
    model = {model[W-2:0], 1'b1};
    push_exp(model[W-1], "R5");

    // R4: clock pin rises while inhibit held high
    for (int k = 0; k < 3; k++) begin
      shift_clk = 1'b1; tick(2);
      shift_clk = 1'b0; tick(2);
    end
    push_exp(model[W-1], "R4");
    clk_inhibit = 1'b0;
    tick(3);
    push_exp(model[W-1], "R4");

    // R4: inhibit pulses while clock pin held high
    load_n = 1'b0; par_in = 8'hC0; tick(1); load_n = 1'b1; tick(1);
    model = 8'hC0;
    ser_in = 1'b0;
    shift_clk = 1'b1;
    tick(2);
    model = {model[W-2:0], 1'b0};
    push_exp(model[W-1], "R3");
    clk_inhibit = 1'b1; tick(2);
    clk_inhibit = 1'b0; tick(2);
    push_exp(model[W-1], "R4");
    shift_clk = 1'b0;
    tick(2);
    pulse_clock(1'b0, "R4");
    push_exp(1'b0, "R4");

    // R1: load overrides clock activity, and an edge during load is dropped
    load_n = 1'b0;
    par_in = 8'h3C;
    for (int k = 0; k < 3; k++) begin
      shift_clk = 1'b1; clk_inhibit = k[0]; ser_in = 1'b1; tick(1);
      shift_clk = 1'b0; tick(1);
    end
    clk_inhibit = 1'b0;
    push_exp(1'b0, "R1");
    shift_clk = 1'b1;
    tick(2);
    load_n = 1'b1;
    model = 8'h3C;
    tick(3);
    push_exp(1'b0, "R1");
    shift_clk = 1'b0;
    tick(2);
    drain("R1");

    tick(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule